// File: doc/BRIEF.md
# Subroutine Stack Sequencer

This block runs the byte-wide stack traffic of a small 8-bit controller whose address space is 13 bits wide. It owns the 8-bit stack pointer and turns one accepted command (push a byte, pull a byte, call, return from subroutine, return from interrupt) into a short, fixed series of single-byte memory accesses. A call or a return then yields a new program counter. A return from interrupt also yields a restored status byte. The stack is not held in a dedicated page. The pointer value, zero-extended, is itself the memory address, so the whole stack sits in page zero.

The surrounding core offers a command when `busy` is low. For a call it also supplies the target and its current program counter. The core watches the single-cycle result strobes. The memory behind the port answers reads in the same cycle the address is driven, and it takes a write on the clock edge that ends the access cycle.

Top module: `stack_seq`

## Requirements
- R1: A push writes its byte at address {0, sp} in one cycle with `mem_we` high, and sp becomes sp-1 at the end of that cycle.
- R2: A pull first moves sp to sp+1 and reads the byte at {0, sp+1} in the same cycle. That byte appears on `pull_data` with a one-cycle `pull_valid` pulse in the following cycle.
- R3: The stack pointer wraps modulo 256. A push at sp=0x00 writes address 0x000 and leaves sp=0xFF. A pull at sp=0xFF reads address 0x000 and leaves sp=0x00.
- R4: A call forms the link value (current pc - 1) mod 8192. It pushes the high byte (link bits 12:8, zero-padded) and then the low byte. In the following cycle it pulses `pc_load` with `pc_out` equal to the call target.
- R5: A subroutine return pulls the low byte and then the high byte. It then pulses `pc_load` with `pc_out` = ({high, low} + 1) mod 8192.
- R6: A return from interrupt pulls the status byte, then the low byte, then the high byte. It then pulses `pc_load` and `status_valid` together, with `pc_out` = {high, low} mod 8192 (no increment) and `status_out` equal to the status byte. `status_valid` is raised by no other command.
- R7: A command is taken when `cmd_valid` is high and `busy` is low. The operation codes are 1 push, 2 pull, 3 call, 4 return, 5 return from interrupt. `busy` is high from the next cycle for exactly 1, 1, 2, 2 or 3 cycles respectively, with one byte access per busy cycle. Results pulse in the cycle after the last access, and a new command can be taken in that same cycle.
- R8: Commands offered while `busy` is high, and operation codes 0, 6 and 7, are ignored: no memory access happens, sp is unchanged and `busy` stays low.
- R9: A synchronous reset sets sp to 0xFF, drops `busy`, clears all result strobes and abandons any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Operation code |
| push_data | input | 8 | Byte to push |
| call_target | input | 13 | Subroutine address for a call |
| cur_pc | input | 13 | Program counter at the call |
| busy | output | 1 | Sequence in progress |
| mem_addr | output | 13 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, same cycle |
| sp | output | 8 | Current stack pointer |
| pull_data | output | 8 | Pulled byte |
| pull_valid | output | 1 | Pulled byte strobe |
| pc_out | output | 13 | New program counter |
| pc_load | output | 1 | New program counter strobe |
| status_out | output | 8 | Restored status byte |
| status_valid | output | 1 | Restored status strobe |

## Verification
Two things can happen in the same cycle: the result strobe of one command and the acceptance of the next command. The bench issues commands back to back, so a pull or return is followed at once by the next command, and it checks the finished result and the new command's first access in consecutive cycles. A second overlap is a command offered on every busy cycle. The reference model's memory and pointer sequence show that these commands were dropped, with no stray write or pointer step.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int SQ_BYTE_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PUSH = 3'd1,
    SQ_PULL = 3'd2,
    SQ_CALL = 3'd3,
    SQ_RET  = 3'd4,
    SQ_RETI = 3'd5
  } sq_op_e;

  function automatic logic [15:0] addr_mask(input int aw);
    return 16'((32'd1 << aw) - 32'd1);
  endfunction

  function automatic logic op_legal(input sq_op_e op);
    return (op == SQ_PUSH) || (op == SQ_PULL) || (op == SQ_CALL) ||
           (op == SQ_RET)  || (op == SQ_RETI);
  endfunction

  function automatic logic op_writes(input sq_op_e op);
    return (op == SQ_PUSH) || (op == SQ_CALL);
  endfunction

  function automatic logic op_reads(input sq_op_e op);
    return (op == SQ_PULL) || (op == SQ_RET) || (op == SQ_RETI);
  endfunction

  function automatic logic [1:0] last_index(input sq_op_e op);
    case (op)
      SQ_CALL, SQ_RET: return 2'd1;
      SQ_RETI:         return 2'd2;
      default:         return 2'd0;
    endcase
  endfunction

  function automatic logic [15:0] call_link(input logic [15:0] pc, input int aw);
    return (pc - 16'd1) & addr_mask(aw);
  endfunction

  function automatic logic [15:0] ret_target(input logic [7:0] hi, input logic [7:0] lo,
                                             input int aw);
    return ({hi, lo} + 16'd1) & addr_mask(aw);
  endfunction

  function automatic logic [15:0] reti_target(input logic [7:0] hi, input logic [7:0] lo,
                                              input int aw);
    return {hi, lo} & addr_mask(aw);
  endfunction

endpackage

// File: rtl/ss_ptr.sv
module ss_ptr #(
  parameter int          PW      = 8,
  parameter logic [7:0]  SP_INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_ev,
  input  logic          inc_ev,
  output logic [PW-1:0] sp,
  output logic [PW-1:0] sp_up
);

  assign sp_up = sp + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= PW'(SP_INIT);
    end else if (dec_ev) begin
      sp <= sp - PW'(1);
    end else if (inc_ev) begin
      sp <= sp_up;
    end
  end

endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import stack_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SQ_BYTE_W-1:0] push_data,
  input  logic [AW-1:0]        call_target,
  input  logic [AW-1:0]        cur_pc,
  output logic                 accept,
  output logic                 busy,
  output sq_op_e               op_q,
  output logic [1:0]           step_q,
  output logic                 last_step,
  output logic                 step_write,
  output logic                 step_read,
  output logic [SQ_BYTE_W-1:0] wbyte,
  output logic [AW-1:0]        target_q
);

  sq_op_e                 op_in;
  logic [AW-1:0]          link_q;
  logic [SQ_BYTE_W-1:0]   data_q;
  logic [15:0]            link_w;

  assign op_in  = sq_op_e'(cmd_op);
  assign accept = cmd_valid && !busy && op_legal(op_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_q     <= SQ_IDLE;
      step_q   <= 2'd0;
      data_q   <= '0;
      link_q   <= '0;
      target_q <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      op_q     <= op_in;
      step_q   <= 2'd0;
      data_q   <= push_data;
      target_q <= call_target;
      link_q   <= AW'(call_link(16'(cur_pc), AW));
    end else if (busy) begin
      if (last_step) begin
        busy <= 1'b0;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign last_step  = busy && (step_q == last_index(op_q));
  assign step_write = busy && op_writes(op_q);
  assign step_read  = busy && op_reads(op_q);

  assign link_w = 16'(link_q);

  always_comb begin
    if (op_q == SQ_CALL) begin
      wbyte = (step_q == 2'd0) ? link_w[15:8] : link_w[7:0];
    end else begin
      wbyte = data_q;
    end
  end

endmodule

// File: rtl/ss_collect.sv
module ss_collect
  import stack_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_read,
  input  logic                 last_step,
  input  sq_op_e               op_q,
  input  logic [1:0]           step_q,
  input  logic [SQ_BYTE_W-1:0] rdata,
  input  logic [AW-1:0]        target_q,
  output logic [SQ_BYTE_W-1:0] pull_data,
  output logic                 pull_valid,
  output logic [AW-1:0]        pc_out,
  output logic                 pc_load,
  output logic [SQ_BYTE_W-1:0] status_out,
  output logic                 status_valid
);

  logic [SQ_BYTE_W-1:0] lo_q;
  logic [SQ_BYTE_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q         <= '0;
      st_q         <= '0;
      pull_data    <= '0;
      pull_valid   <= 1'b0;
      pc_out       <= '0;
      pc_load      <= 1'b0;
      status_out   <= '0;
      status_valid <= 1'b0;
    end else begin
      pull_valid   <= 1'b0;
      pc_load      <= 1'b0;
      status_valid <= 1'b0;
      if (step_read) begin
        if (op_q == SQ_RET && step_q == 2'd0) lo_q <= rdata;
        if (op_q == SQ_RETI && step_q == 2'd0) st_q <= rdata;
        if (op_q == SQ_RETI && step_q == 2'd1) lo_q <= rdata;
      end
      if (last_step) begin
        case (op_q)
          SQ_PULL: begin
            pull_data  <= rdata;
            pull_valid <= 1'b1;
          end
          SQ_CALL: begin
            pc_out  <= target_q;
            pc_load <= 1'b1;
          end
          SQ_RET: begin
            pc_out  <= AW'(ret_target(rdata, lo_q, AW));
            pc_load <= 1'b1;
          end
          SQ_RETI: begin
            pc_out       <= AW'(reti_target(rdata, lo_q, AW));
            pc_load      <= 1'b1;
            status_out   <= st_q;
            status_valid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int         AW      = 13,
  parameter logic [7:0] SP_INIT = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SQ_BYTE_W-1:0] push_data,
  input  logic [AW-1:0]        call_target,
  input  logic [AW-1:0]        cur_pc,
  output logic                 busy,
  output logic [AW-1:0]        mem_addr,
  output logic [SQ_BYTE_W-1:0] mem_wdata,
  output logic                 mem_we,
  input  logic [SQ_BYTE_W-1:0] mem_rdata,
  output logic [SQ_BYTE_W-1:0] sp,
  output logic [SQ_BYTE_W-1:0] pull_data,
  output logic                 pull_valid,
  output logic [AW-1:0]        pc_out,
  output logic                 pc_load,
  output logic [SQ_BYTE_W-1:0] status_out,
  output logic                 status_valid
);

  localparam int PAD_W = AW - SQ_BYTE_W;

  logic                 accept;
  sq_op_e               op_q;
  logic [1:0]           step_q;
  logic                 last_step;
  logic                 ev_wr;
  logic                 ev_rd;
  logic [SQ_BYTE_W-1:0] wbyte;
  logic [AW-1:0]        target_q;
  logic [SQ_BYTE_W-1:0] sp_up;
  logic [SQ_BYTE_W-1:0] stack_slot;

  ss_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .push_data   (push_data),
    .call_target (call_target),
    .cur_pc      (cur_pc),
    .accept      (accept),
    .busy        (busy),
    .op_q        (op_q),
    .step_q      (step_q),
    .last_step   (last_step),
    .step_write  (ev_wr),
    .step_read   (ev_rd),
    .wbyte       (wbyte),
    .target_q    (target_q)
  );

  ss_ptr #(.PW(SQ_BYTE_W), .SP_INIT(SP_INIT)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .dec_ev (ev_wr),
    .inc_ev (ev_rd),
    .sp     (sp),
    .sp_up  (sp_up)
  );

  ss_collect #(.AW(AW)) u_coll (
    .clk          (clk),
    .rst          (rst),
    .step_read    (ev_rd),
    .last_step    (last_step),
    .op_q         (op_q),
    .step_q       (step_q),
    .rdata        (mem_rdata),
    .target_q     (target_q),
    .pull_data    (pull_data),
    .pull_valid   (pull_valid),
    .pc_out       (pc_out),
    .pc_load      (pc_load),
    .status_out   (status_out),
    .status_valid (status_valid)
  );

  assign stack_slot = ev_rd ? sp_up : sp;
  assign mem_addr   = {{PAD_W{1'b0}}, stack_slot};
  assign mem_we     = ev_wr;
  assign mem_wdata  = ev_wr ? wbyte : '0;

endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          accept,
  input logic          mem_we,
  input logic          ev_rd,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    sp,
  input logic          pull_valid,
  input logic          pc_load,
  input logic          status_valid
);

  localparam int PAD_W = AW - 8;

  AST_WRITE_AT_POINTER: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == {{PAD_W{1'b0}}, sp}); // R1

  AST_WRITE_THEN_DOWN: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> sp == 8'($past(sp) - 8'd1)); // R1

  AST_READ_THEN_UP: assert property (@(posedge clk) disable iff (rst)
    ev_rd |=> sp == 8'($past(sp) + 8'd1)); // R2

  AST_READ_AT_NEXT: assert property (@(posedge clk) disable iff (rst)
    ev_rd |-> mem_addr == {{PAD_W{1'b0}}, 8'(sp + 8'd1)}); // R3

  AST_STATUS_WITH_PC: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> pc_load); // R6

  AST_PULL_NOT_PC: assert property (@(posedge clk) disable iff (rst)
    pull_valid |-> !pc_load); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy); // R7

  AST_IDLE_HOLDS_SP: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(sp)); // R7

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we && !ev_rd); // R8

endmodule

bind stack_seq ss_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .accept       (accept),
  .mem_we       (mem_we),
  .ev_rd        (ev_rd),
  .mem_addr     (mem_addr),
  .sp           (sp),
  .pull_valid   (pull_valid),
  .pc_load      (pc_load),
  .status_valid (status_valid)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;

  localparam int AW    = 13;
  localparam int AMASK = 32'h1FFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [7:0]    push_data = 8'd0;
  logic [AW-1:0] call_target = '0;
  logic [AW-1:0] cur_pc = '0;
  logic          busy;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we;
  logic [7:0]    mem_rdata;
  logic [7:0]    sp;
  logic [7:0]    pull_data;
  logic          pull_valid;
  logic [AW-1:0] pc_out;
  logic          pc_load;
  logic [7:0]    status_out;
  logic          status_valid;

  always #10 clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .call_target(call_target), .cur_pc(cur_pc),
    .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .sp(sp), .pull_data(pull_data), .pull_valid(pull_valid),
    .pc_out(pc_out), .pc_load(pc_load), .status_out(status_out),
    .status_valid(status_valid)
  );

  // memory behind the port: page zero only
  logic [7:0] ram [256];
  always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = ram[mem_addr[7:0]];

  // reference model state
  int ref_mem [256];
  int ref_sp;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit exp_pl, exp_pv, exp_sv;
  int exp_pc, exp_pd, exp_st;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_results();
    chk("R7", "pc_load strobe", 32'(pc_load), 32'(exp_pl));
    chk("R2", "pull_valid strobe", 32'(pull_valid), 32'(exp_pv));
    chk("R6", "status_valid strobe", 32'(status_valid), 32'(exp_sv));
    if (exp_pv) chk("R2", "pulled byte", 32'(pull_data), exp_pd);
    if (exp_pl) chk(exp_sv ? "R6" : "R5", "new pc", 32'(pc_out), exp_pc);
    if (exp_sv) chk("R6", "status byte", 32'(status_out), exp_st);
    exp_pl = 0; exp_pv = 0; exp_sv = 0;
  endtask

  task automatic do_cmd(input int op, input int data, input int tgt, input int pc,
                        input bit noise);
    int wl[$];
    int rd[$];
    int n;
    int link;
    string tag;
    @(negedge clk);
    check_results();
    chk("R7", "idle before accept", 32'(busy), 0);
    cmd_valid = 1'b1; cmd_op = 3'(op); push_data = 8'(data);
    call_target = AW'(tgt); cur_pc = AW'(pc);
    link = (pc - 1) & AMASK;
    case (op)
      1: begin n = 1; wl.push_back(data & 255); tag = "R1"; end
      2: begin n = 1; tag = "R2"; end
      3: begin n = 2; wl.push_back(link >> 8); wl.push_back(link & 255); tag = "R4"; end
      4: begin n = 2; tag = "R5"; end
      default: begin n = 3; tag = "R6"; end
    endcase
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (noise) begin
        cmd_valid = 1'b1; cmd_op = 3'd1; push_data = 8'hEE;   // R8 offered while busy
      end else begin
        cmd_valid = 1'b0;
      end
      chk("R7", "busy during sequence", 32'(busy), 1);
      chk("R7", "no early pc strobe", 32'(pc_load), 0);
      chk(tag, "sp before access", 32'(sp), ref_sp);
      if (op == 1 || op == 3) begin
        chk(tag, "write enable", 32'(mem_we), 1);
        chk(tag, "write address", 32'(mem_addr), ref_sp);
        chk(tag, "write byte", 32'(mem_wdata), wl[k]);
        ref_mem[ref_sp] = wl[k];
        ref_sp = (ref_sp - 1) & 255;
      end else begin
        ref_sp = (ref_sp + 1) & 255;
        chk(tag, "no write on read", 32'(mem_we), 0);
        chk(tag, "read address", 32'(mem_addr), ref_sp);
        rd.push_back(ref_mem[ref_sp]);
      end
    end
    case (op)
      2: begin exp_pv = 1; exp_pd = rd[0]; end
      3: begin exp_pl = 1; exp_pc = tgt & AMASK; end
      4: begin exp_pl = 1; exp_pc = (((rd[1] << 8) | rd[0]) + 1) & AMASK; end
      5: begin exp_pl = 1; exp_sv = 1; exp_st = rd[0];
               exp_pc = ((rd[2] << 8) | rd[1]) & AMASK; end
      default: ;
    endcase
  endtask

  task automatic idle_cyc(input int op);
    @(negedge clk);
    check_results();
    cmd_valid = (op >= 0); cmd_op = 3'(op); push_data = 8'h99;
    chk("R8", "stays idle", 32'(busy), 0);
    chk("R8", "no write when idle", 32'(mem_we), 0);
    chk("R8", "sp unchanged", 32'(sp), ref_sp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'((i * 37 + 5) & 255);
      ref_mem[i] = (i * 37 + 5) & 255;
    end
    ref_sp = 255;
    exp_pl = 0; exp_pv = 0; exp_sv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "sp after reset", 32'(sp), 32'hFF);
    chk("R9", "busy after reset", 32'(busy), 0);
    chk("R9", "strobes after reset", 32'({pc_load, pull_valid, status_valid}), 0);

    do_cmd(1, 'hA5, 0, 0, 0);                 // R1 push
    do_cmd(2, 0, 0, 0, 0);                    // R2 pull, back to back
    do_cmd(3, 'h1234, 'h0800, 0, 1);          // R4 call with noise (R8)
    do_cmd(4, 0, 0, 0, 1);                    // R5 return
    do_cmd(3, 'h0100, 'h0000, 0, 0);          // R4 link wraps to 0x1FFF
    do_cmd(4, 0, 0, 0, 0);                    // R5 return wraps to 0x0000
    do_cmd(1, 'h12, 0, 0, 0);
    do_cmd(1, 'h34, 0, 0, 0);
    do_cmd(1, 'hC3, 0, 0, 1);
    do_cmd(5, 0, 0, 0, 0);                    // R6 status, pc 0x1234 unchanged
    do_cmd(2, 0, 0, 0, 0);                    // R3 pull at 0xFF reads 0x000
    idle_cyc(-1);
    chk("R3", "sp wrapped up to 00", 32'(sp), 0);
    do_cmd(1, 'h77, 0, 0, 0);                 // R3 push at 0x00
    idle_cyc(-1);
    chk("R3", "sp wrapped down to FF", 32'(sp), 32'hFF);
    idle_cyc(6);                              // R8 illegal codes
    idle_cyc(7);
    idle_cyc(0);
    idle_cyc(-1);
    do_cmd(2, 0, 0, 0, 0);                    // R3 re-read wrapped write
    idle_cyc(-1);

    // R9 reset in the middle of a return
    @(negedge clk);
    check_results();
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ref_sp = 255;
    chk("R9", "sp after mid reset", 32'(sp), 32'hFF);
    chk("R9", "busy after mid reset", 32'(busy), 0);
    chk("R9", "no pc strobe after reset", 32'(pc_load), 0);
    idle_cyc(-1);
    do_cmd(1, 'h5A, 0, 0, 0);
    do_cmd(2, 0, 0, 0, 0);
    idle_cyc(-1);
    idle_cyc(-1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule